// File: doc/BRIEF.md
# Pop-Free Output Power Sequencer

This block steps an audio output path through ordered power transitions so that no click reaches the load. It drives four control bits: the reference/midrail enable, the converter enable, the output driver enable and the DAC mute. Power-up turns on the reference, waits for it to settle, then turns on the converters and the drivers, and releases the mute last. Power-down always mutes first. It then either walks the path down fully, or drops only the reference so the midrail discharges quickly and the drivers stay on.

The settle wait is loaded from a 16-bit input each time a power-up starts, and it is counted in clock cycles. Every later step is spaced by a fixed gap of `GAP_CYCLES + 1` cycles, so each bit changes in a cycle of its own. While a sequence runs, `busy` is high and all requests are ignored. A one-cycle `done` pulse marks the final step.

Top module: `pwr_seq_top`

## Requirements
- R1: During and after reset, with no request: `dacMute` = 1, `refEn` = `convEn` = `outEn` = 0, `busy` = 0, `done` = 0.
- R2: In standby, the clock edge that samples `upReq` = 1 sets `refEn` and loads `settleCount` = N. `convEn` rises exactly N+1 cycles after `refEn` rises.
- R3: During power-up, `outEn` rises GAP_CYCLES+1 cycles after `convEn`. `dacMute` falls GAP_CYCLES+1 cycles after that.
- R4: When powered, `downReq` = 1 with `quickSel` = 0 starts the low-noise power-down. `dacMute` rises on the sampling edge. Then `outEn`, `convEn` and `refEn` each fall in turn, GAP_CYCLES+1 cycles apart.
- R5: When powered, `downReq` = 1 with `quickSel` = 1 starts the quick power-down. `dacMute` rises on the sampling edge and `refEn` falls GAP_CYCLES+1 cycles later. `convEn` and `outEn` stay at 1.
- R6: `busy` is 1 from the first step's edge until the final step's edge and 0 afterwards. `done` is 1 for exactly one cycle, on the final step's edge.
- R7: `upReq` and `downReq` are ignored while `busy` = 1. The running sequence keeps its timing and produces one `done` pulse.
- R8: `downReq` in standby and `upReq` when powered change no output, do not raise `busy` and produce no `done`.
- R9: A power-up after a quick power-down completes with the timing of R2/R3, with `convEn` and `outEn` staying at 1 throughout. A following low-noise power-down clears them.
- R10: At most one of the four control bits changes in any cycle. The reference, converter and output enables change only while `dacMute` = 1. `convEn` rises only with `refEn` = 1. `dacMute` falls only with all three enables at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| upReq | input | 1 | Power-up request |
| downReq | input | 1 | Power-down request |
| quickSel | input | 1 | 1 selects the quick-discharge power-down, 0 the low-noise one |
| settleCount | input | 16 | Reference settle wait in cycles, loaded when power-up starts |
| refEn | output | 1 | Reference and midrail enable |
| convEn | output | 1 | Converter enable |
| outEn | output | 1 | Output driver enable |
| dacMute | output | 1 | DAC mute, 1 = muted |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The assertions guard the ordering invariants on every cycle:
- no two control bits change together and no enable moves while unmuted;
- the converters never rise without the reference and the mute never releases into a partly powered path;
- `done` never lasts two cycles and the controller never fires two steps at once.

The exact spacing of each step (the settle count plus one, then the gap) can only be shown by the bench's timed scenarios. The same holds for requests being ignored while busy or in the matching state, and for the quick power-down leaving the drivers on through the next power-up.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_UP_CONV,
    ST_UP_OUT,
    ST_UP_UNMUTE,
    ST_ON,
    ST_DN_OUT,
    ST_DN_CONV,
    ST_DN_REF
  } seqState_t;

  typedef struct packed {
    logic loadSettle;
    logic loadGap;
    logic setRef;
    logic clrRef;
    logic setConv;
    logic clrConv;
    logic setOut;
    logic clrOut;
    logic setMute;
    logic clrMute;
    logic finish;
  } seqStrobe_t;

endpackage

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       upReq,
  input  logic       downReq,
  input  logic       quickSel,
  input  logic       timerDone,
  output seqStrobe_t stb,
  output logic       busy
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_OFF: if (upReq) begin
        stb.setRef     = 1'b1;
        stb.loadSettle = 1'b1;
        stateNext      = ST_UP_CONV;
      end
      ST_UP_CONV: if (timerDone) begin
        stb.setConv = 1'b1;
        stb.loadGap = 1'b1;
        stateNext   = ST_UP_OUT;
      end
      ST_UP_OUT: if (timerDone) begin
        stb.setOut  = 1'b1;
        stb.loadGap = 1'b1;
        stateNext   = ST_UP_UNMUTE;
      end
      ST_UP_UNMUTE: if (timerDone) begin
        stb.clrMute = 1'b1;
        stb.finish  = 1'b1;
        stateNext   = ST_ON;
      end
      ST_ON: if (downReq) begin
        stb.setMute = 1'b1;
        stb.loadGap = 1'b1;
        stateNext   = quickSel ? ST_DN_REF : ST_DN_OUT;
      end
      ST_DN_OUT: if (timerDone) begin
        stb.clrOut  = 1'b1;
        stb.loadGap = 1'b1;
        stateNext   = ST_DN_CONV;
      end
      ST_DN_CONV: if (timerDone) begin
        stb.clrConv = 1'b1;
        stb.loadGap = 1'b1;
        stateNext   = ST_DN_REF;
      end
      ST_DN_REF: if (timerDone) begin
        stb.clrRef = 1'b1;
        stb.finish = 1'b1;
        stateNext  = ST_OFF;
      end
      default: stateNext = ST_OFF;
    endcase
  end

  assign busy = (state != ST_OFF) && (state != ST_ON);

  // R10
  one_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setRef, stb.clrRef, stb.setConv, stb.clrConv,
              stb.setOut, stb.clrOut, stb.setMute, stb.clrMute}));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && !upReq) |=> (state == ST_OFF));

endmodule

// File: rtl/pwrseq_path.sv
module pwrseq_path
  import pwrseq_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int GAP_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  logic [CNT_W-1:0] settleCount,
  output logic             timerDone,
  output logic             refEn,
  output logic             convEn,
  output logic             outEn,
  output logic             dacMute,
  output logic             done
);

  localparam logic [CNT_W-1:0] GapLoad = CNT_W'(GAP_CYCLES);

  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              waitCnt <= '0;
    else if (stb.loadSettle) waitCnt <= settleCount;
    else if (stb.loadGap)    waitCnt <= GapLoad;
    else if (waitCnt != '0)  waitCnt <= waitCnt - 1'b1;
  end

  assign timerDone = (waitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refEn   <= 1'b0;
      convEn  <= 1'b0;
      outEn   <= 1'b0;
      dacMute <= 1'b1;
      done    <= 1'b0;
    end else begin
      if (stb.setRef)       refEn   <= 1'b1;
      else if (stb.clrRef)  refEn   <= 1'b0;
      if (stb.setConv)      convEn  <= 1'b1;
      else if (stb.clrConv) convEn  <= 1'b0;
      if (stb.setOut)       outEn   <= 1'b1;
      else if (stb.clrOut)  outEn   <= 1'b0;
      if (stb.setMute)      dacMute <= 1'b1;
      else if (stb.clrMute) dacMute <= 1'b0;
      done <= stb.finish;
    end
  end

  // R10
  single_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({refEn, convEn, outEn, dacMute} ^
               $past({refEn, convEn, outEn, dacMute})) <= 1);

  // R10
  muted_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(refEn) || !$stable(convEn) || !$stable(outEn)) |-> dacMute);

  // R10
  conv_needs_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convEn) |-> refEn);

  // R3
  unmute_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dacMute) |-> (refEn && convEn && outEn));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top #(
  parameter int CNT_W      = 16,
  parameter int GAP_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             upReq,
  input  logic             downReq,
  input  logic             quickSel,
  input  logic [CNT_W-1:0] settleCount,
  output logic             refEn,
  output logic             convEn,
  output logic             outEn,
  output logic             dacMute,
  output logic             busy,
  output logic             done
);

  pwrseq_pkg::seqStrobe_t stb;
  logic timerDone;

  pwrseq_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .upReq     (upReq),
    .downReq   (downReq),
    .quickSel  (quickSel),
    .timerDone (timerDone),
    .stb       (stb),
    .busy      (busy)
  );

  pwrseq_path #(
    .CNT_W      (CNT_W),
    .GAP_CYCLES (GAP_CYCLES)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .settleCount (settleCount),
    .timerDone   (timerDone),
    .refEn       (refEn),
    .convEn      (convEn),
    .outEn       (outEn),
    .dacMute     (dacMute),
    .done        (done)
  );

  // R6
  busy_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: tb/tb_pwr_seq_top.sv
`timescale 1ns/1ps
module tb_pwr_seq_top;
  localparam int G = 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic upReq = 1'b0, downReq = 1'b0, quickSel = 1'b0;
  logic [15:0] settleCount = '0;
  logic refEn, convEn, outEn, dacMute, busy, done;

  pwr_seq_top #(.CNT_W(16), .GAP_CYCLES(G)) dut (
    .clk(clk), .rstN(rstN), .upReq(upReq), .downReq(downReq),
    .quickSel(quickSel), .settleCount(settleCount),
    .refEn(refEn), .convEn(convEn), .outEn(outEn), .dacMute(dacMute),
    .busy(busy), .done(done)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;
  int tRef, tConv, tOut, tMute, tDone, doneCnt, tBusyRise, tBusyFall;

  always @(posedge clk) cyc++;

  initial begin
    wait (cyc >= 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runSeq(bit up, bit dn, bit q, logic [15:0] n,
                        int injK, bit injUp, bit injDn, int maxCyc);
    logic pr, pc, po, pm;
    @(negedge clk);
    pr = refEn; pc = convEn; po = outEn; pm = dacMute;
    tRef = -1; tConv = -1; tOut = -1; tMute = -1; tDone = -1;
    doneCnt = 0; tBusyRise = -1; tBusyFall = -1;
    upReq = up; downReq = dn; quickSel = q; settleCount = n;
    for (int k = 0; k < maxCyc; k++) begin
      @(negedge clk);
      upReq = 1'b0; downReq = 1'b0;
      if (tRef  < 0 && refEn   !== pr) tRef  = k;
      if (tConv < 0 && convEn  !== pc) tConv = k;
      if (tOut  < 0 && outEn   !== po) tOut  = k;
      if (tMute < 0 && dacMute !== pm) tMute = k;
      if (done === 1'b1) begin doneCnt++; if (tDone < 0) tDone = k; end
      if (busy === 1'b1 && tBusyRise < 0) tBusyRise = k;
      if (busy === 1'b0 && tBusyRise >= 0 && tBusyFall < 0) tBusyFall = k;
      if (k == injK) begin upReq = injUp; downReq = injDn; end
    end
  endtask

  task automatic checkUp(string tag, int n, bit fromQuick);
    int last;
    last = n + 3 + 2*G;
    chk({tag, " R2 ref"}, tRef, 0);
    chk({tag, " R2 conv"}, tConv, fromQuick ? -1 : n + 1);
    chk({tag, " R3 out"}, tOut, fromQuick ? -1 : n + 2 + G);
    chk({tag, " R3 unmute"}, tMute, last);
    chk({tag, " R6 done"}, tDone, last);
    chk({tag, " R6 doneCnt"}, doneCnt, 1);
    chk({tag, " R6 busyRise"}, tBusyRise, 0);
    chk({tag, " R6 busyFall"}, tBusyFall, last);
  endtask

  task automatic checkDownSlow(string tag);
    chk({tag, " R4 mute"}, tMute, 0);
    chk({tag, " R4 out"}, tOut, G + 1);
    chk({tag, " R4 conv"}, tConv, 2*(G + 1));
    chk({tag, " R4 ref"}, tRef, 3*(G + 1));
    chk({tag, " R6 done"}, tDone, 3*(G + 1));
    chk({tag, " R6 doneCnt"}, doneCnt, 1);
    chk({tag, " R6 busyFall"}, tBusyFall, 3*(G + 1));
  endtask

  task automatic checkQuiet(string tag);
    chk({tag, " R8 ref"}, tRef, -1);
    chk({tag, " R8 conv"}, tConv, -1);
    chk({tag, " R8 out"}, tOut, -1);
    chk({tag, " R8 mute"}, tMute, -1);
    chk({tag, " R8 done"}, doneCnt, 0);
    chk({tag, " R8 busy"}, tBusyRise, -1);
  endtask

  initial begin
    int nList[6] = '{0, 1, 2, 5, 9, 1000};
    repeat (3) @(negedge clk);
    chk("R1 mute in reset", int'(dacMute), 1);
    chk("R1 enables in reset", int'({refEn, convEn, outEn}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 mute after reset", int'(dacMute), 1);
    chk("R1 enables after reset", int'({refEn, convEn, outEn}), 0);
    chk("R1 busy/done", int'({busy, done}), 0);

    runSeq(1'b0, 1'b1, 1'b0, 16'd0, -1, 1'b0, 1'b0, 8);
    checkQuiet("down in standby");

    foreach (nList[i]) begin
      runSeq(1'b1, 1'b0, 1'b0, 16'(nList[i]), -1, 1'b0, 1'b0, nList[i] + 3 + 2*G + 4);
      checkUp($sformatf("up n=%0d", nList[i]), nList[i], 1'b0);
      runSeq(1'b1, 1'b0, 1'b0, 16'd3, -1, 1'b0, 1'b0, 8);
      checkQuiet($sformatf("up when on n=%0d", nList[i]));
      runSeq(1'b0, 1'b1, 1'b0, 16'd0, -1, 1'b0, 1'b0, 3*(G + 1) + 4);
      checkDownSlow($sformatf("slow down n=%0d", nList[i]));
      chk("R4 final state", int'({refEn, convEn, outEn, dacMute}), 1);
    end

    // R5 quick power-down
    runSeq(1'b1, 1'b0, 1'b0, 16'd3, -1, 1'b0, 1'b0, 3 + 3 + 2*G + 4);
    checkUp("pre-quick up", 3, 1'b0);
    runSeq(1'b0, 1'b1, 1'b1, 16'd0, -1, 1'b0, 1'b0, G + 6);
    chk("R5 mute", tMute, 0);
    chk("R5 ref", tRef, G + 1);
    chk("R5 out kept", tOut, -1);
    chk("R5 conv kept", tConv, -1);
    chk("R5 done", tDone, G + 1);
    chk("R5 final state", int'({refEn, convEn, outEn, dacMute}), 4'b0111);

    runSeq(1'b0, 1'b1, 1'b0, 16'd0, -1, 1'b0, 1'b0, 8);
    checkQuiet("down after quick");
    chk("R8 outputs still on", int'(outEn), 1);

    // R9 power-up after quick, then slow down
    runSeq(1'b1, 1'b0, 1'b0, 16'd4, -1, 1'b0, 1'b0, 4 + 3 + 2*G + 4);
    checkUp("R9 up after quick", 4, 1'b1);
    runSeq(1'b0, 1'b1, 1'b0, 16'd0, -1, 1'b0, 1'b0, 3*(G + 1) + 4);
    checkDownSlow("R9 slow down");
    chk("R9 final state", int'({refEn, convEn, outEn, dacMute}), 1);

    // R7 requests while busy
    runSeq(1'b1, 1'b0, 1'b0, 16'd10, 2, 1'b0, 1'b1, 10 + 3 + 2*G + 4);
    checkUp("R7 down during up", 10, 1'b0);
    runSeq(1'b1, 1'b0, 1'b0, 16'd0, 12, 1'b1, 1'b1, 6);
    checkQuiet("R7 settled on");
    runSeq(1'b0, 1'b1, 1'b0, 16'd0, 1, 1'b1, 1'b0, 3*(G + 1) + 4);
    checkDownSlow("R7 up during down");
    runSeq(1'b1, 1'b0, 1'b0, 16'd2, -1, 1'b0, 1'b0, 2 + 3 + 2*G + 4);
    checkUp("R7 pre-quick", 2, 1'b0);
    runSeq(1'b0, 1'b1, 1'b1, 16'd0, 0, 1'b1, 1'b0, G + 6);
    chk("R7 quick ref", tRef, G + 1);
    chk("R7 quick done count", doneCnt, 1);
    chk("R7 quick final", int'({refEn, convEn, outEn, dacMute}), 4'b0111);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule